// File: doc/BRIEF.md
# SPI Slave-Select and Master Arbitration Manager

This block decides which role an SPI peripheral plays on a shared bus and drives the slave-select line accordingly. It holds a small configuration word: a master request, an enable, a choice between a software-driven and a pin-driven select source, the software select level, and a select-output enable. From these it derives the internal select level, tells the shift engine whether it is addressed as a slave, and drives the select pin low for as long as it is an enabled master with the output enabled.

Several masters can share one bus. Each master leaves its select output released and watches the select pin instead. If another master pulls the line low, the internal level drops while this block is master, and it reports a mode fault. On that fault it gives up the master role and the enable on its own, and it sets a sticky flag. The shift engine is not part of this block. It is represented by a byte-in-progress input and an abort pulse back to it.

Top module: `ssel_manager`

## Requirements
- R1: While the software-select bit (configuration bit 2) is 1, `nss_int` equals the software level bit (configuration bit 3), and `nss_pin_i` has no effect on it.
- R2: While bit 2 is 0, `nss_int` follows `nss_pin_i` through a two-flop synchronizer. A change on the pin appears on `nss_int` after exactly two rising clock edges.
- R3: While master (bit 0), enable (bit 1) and select-output enable (bit 4) are all 1, `nss_pin_oe` is 1 and `nss_pin_o` is 0. This holds on every cycle, whatever `byte_busy` does.
- R4: When the block is disabled or bit 4 is 0, `nss_pin_oe` is 0, so the pin floats.
- R5: A mode fault is a cycle in which `ctl_master` is 1 and `nss_int` is 0. At the next edge `ctl_master` and `ctl_enable` become 0, `nss_pin_oe` becomes 0 and `mode_fault` becomes 1. This takes priority over a configuration write in the same cycle.
- R6: `slv_sel` is 1 exactly when the block is enabled, is not master, and `nss_int` is 0.
- R7: `mode_fault` is sticky. It clears one edge after `fault_clr`, unless a new fault occurs in that same cycle, in which case it stays set.
- R8: A write with bit 0 set produces master only if `mode_fault` is 0 and the select level that results from the written bits is high. Otherwise `ctl_master` stays 0, and the other fields are still written.
- R9: If `byte_busy` is 1 in a cycle where the block is an enabled slave with `nss_int` high, `byte_abort` is 1 in the following cycle.
- R10: After reset every configuration bit is 0, `mode_fault` and `byte_abort` are 0, and the synchronizer holds 1, so `nss_int` is 1.
- R11: A cycle with `cfg_we` at 1 loads the 5-bit `cfg_wdata` at that edge, using the bit layout above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word (bit0 master, bit1 enable, bit2 software select, bit3 software level, bit4 output enable) |
| fault_clr | input | 1 | Clears the sticky mode-fault flag |
| byte_busy | input | 1 | Shift engine has a byte in progress |
| nss_pin_i | input | 1 | Select pin input level |
| nss_pin_o | output | 1 | Select pin output value (always low) |
| nss_pin_oe | output | 1 | Select pin output enable |
| nss_int | output | 1 | Effective internal select level |
| slv_sel | output | 1 | Addressed as slave |
| byte_abort | output | 1 | Discard the partial byte |
| mode_fault | output | 1 | Sticky mode-fault flag |
| ctl_master | output | 1 | Current master bit |
| ctl_enable | output | 1 | Current enable bit |

## Verification
A wrong role bit shows at the ports within one cycle. It appears on `nss_pin_oe` and `slv_sel`, and a master that misses a low select keeps driving the pin on the edge where R5 requires it to release. A wrong synchronizer depth shifts every pin-driven change of `nss_int` and `slv_sel` by a cycle. A fault flag that is not sticky, or a master write that slips through while the flag is set, shows on `mode_fault` or `ctl_master` at the next edge. The bench checks every output on every cycle against its own model, using directed sequences followed by a long random stretch.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
   localparam int CFG_MST  = 0;
   localparam int CFG_EN   = 1;
   localparam int CFG_SSM  = 2;
   localparam int CFG_SSI  = 3;
   localparam int CFG_SSOE = 4;

   typedef struct packed {
      logic ssoe;
      logic ssi;
      logic ssm;
      logic en;
      logic mst;
   } ssel_cfg_t;

   localparam int CFG_W = $bits(ssel_cfg_t);

   // select level that a given configuration produces from a synced pin
   function automatic logic sel_level(input ssel_cfg_t c, input logic pin_s);
      return c.ssm ? c.ssi : pin_s;
   endfunction
endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial begin
      if (STAGES < 2) $error("ssel_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RESET_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssel_cfg_reg.sv
module ssel_cfg_reg
   import ssel_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   input  logic             fault_now,
   input  logic             fault_q,
   input  logic             pin_s,
   output ssel_cfg_t        cfg_q
);
   ssel_cfg_t wr_cfg;
   ssel_cfg_t cfg_d;
   logic      mst_ok;

   always_comb begin
      wr_cfg = ssel_cfg_t'(wdata);
      // master only granted with no pending fault and a high resulting level
      mst_ok = wr_cfg.mst & ~fault_q & sel_level(wr_cfg, pin_s);
      cfg_d  = cfg_q;
      if (we) begin
         cfg_d     = wr_cfg;
         cfg_d.mst = mst_ok;
      end
      if (fault_now) begin
         cfg_d.mst = 1'b0;
         cfg_d.en  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else        cfg_q <= cfg_d;
   end
endmodule

// File: rtl/ssel_fault.sv
module ssel_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_now,
   input  logic clr,
   output logic fault_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fault_q <= 1'b0;
      else if (fault_now) fault_q <= 1'b1;
      else if (clr)       fault_q <= 1'b0;
   end
endmodule

// File: rtl/ssel_slave.sv
module ssel_slave (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mst,
   input  logic nss_lvl,
   input  logic busy,
   output logic sel,
   output logic abort_q
);
   logic slave_role;

   assign slave_role = en & ~mst;
   assign sel        = slave_role & ~nss_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_q <= 1'b0;
      else        abort_q <= slave_role & nss_lvl & busy;
   end
endmodule

// File: rtl/ssel_manager.sv
module ssel_manager
   import ssel_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             fault_clr,
   input  logic             byte_busy,
   input  logic             nss_pin_i,
   output logic             nss_pin_o,
   output logic             nss_pin_oe,
   output logic             nss_int,
   output logic             slv_sel,
   output logic             byte_abort,
   output logic             mode_fault,
   output logic             ctl_master,
   output logic             ctl_enable
);
   initial begin
      if (CFG_W != 5) $error("ssel_manager: configuration width mismatch");
   end

   ssel_cfg_t cfg_q;
   logic      pin_s;
   logic      fault_now;

   ssel_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(nss_pin_i), .q(pin_s)
   );

   assign nss_int   = sel_level(cfg_q, pin_s);
   assign fault_now = cfg_q.mst & ~nss_int;

   ssel_cfg_reg u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
      .fault_now(fault_now), .fault_q(mode_fault), .pin_s(pin_s),
      .cfg_q(cfg_q)
   );

   ssel_fault u_fault (
      .clk(clk), .rst_n(rst_n), .fault_now(fault_now), .clr(fault_clr),
      .fault_q(mode_fault)
   );

   ssel_slave u_slave (
      .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .mst(cfg_q.mst),
      .nss_lvl(nss_int), .busy(byte_busy), .sel(slv_sel), .abort_q(byte_abort)
   );

   assign nss_pin_o  = 1'b0;
   assign nss_pin_oe = cfg_q.mst & cfg_q.en & cfg_q.ssoe;
   assign ctl_master = cfg_q.mst;
   assign ctl_enable = cfg_q.en;
endmodule

// File: rtl/ssel_checker.sv
module ssel_checker (
   input logic clk,
   input logic rst_n,
   input logic fault_clr,
   input logic byte_busy,
   input logic nss_pin_o,
   input logic nss_pin_oe,
   input logic nss_int,
   input logic slv_sel,
   input logic byte_abort,
   input logic mode_fault,
   input logic ctl_master,
   input logic ctl_enable
);
   p_drive_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      nss_pin_oe |-> (nss_pin_o == 1'b0));

   p_release_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |-> !nss_pin_oe);

   p_fault_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_master && !nss_int) |=> (!ctl_master && !ctl_enable && !nss_pin_oe && mode_fault));

   p_slave_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slv_sel |-> (!nss_int && !ctl_master && ctl_enable));

   p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_fault && !fault_clr) |=> mode_fault);

   p_no_reentry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault |=> !ctl_master);

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_busy && ctl_enable && !ctl_master && nss_int) |=> byte_abort);
endmodule

bind ssel_manager ssel_checker u_chk (
   .clk(clk), .rst_n(rst_n), .fault_clr(fault_clr), .byte_busy(byte_busy),
   .nss_pin_o(nss_pin_o), .nss_pin_oe(nss_pin_oe), .nss_int(nss_int),
   .slv_sel(slv_sel), .byte_abort(byte_abort), .mode_fault(mode_fault),
   .ctl_master(ctl_master), .ctl_enable(ctl_enable)
);

// File: tb/sim_ssel_manager.sv
module sim_ssel_manager;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic       fault_clr = 1'b0;
   logic       byte_busy = 1'b0;
   logic       nss_pin_i = 1'b1;
   logic       nss_pin_o, nss_pin_oe, nss_int, slv_sel, byte_abort;
   logic       mode_fault, ctl_master, ctl_enable;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ssel_manager u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .fault_clr(fault_clr), .byte_busy(byte_busy), .nss_pin_i(nss_pin_i),
      .nss_pin_o(nss_pin_o), .nss_pin_oe(nss_pin_oe), .nss_int(nss_int),
      .slv_sel(slv_sel), .byte_abort(byte_abort), .mode_fault(mode_fault),
      .ctl_master(ctl_master), .ctl_enable(ctl_enable)
   );

   // behavioural reference
   bit m_mst, m_en, m_ssm, m_ssi, m_ssoe, m_fault, m_abort;
   bit pin_q[$];

   task automatic model_reset();
      m_mst = 0; m_en = 0; m_ssm = 0; m_ssi = 0; m_ssoe = 0;
      m_fault = 0; m_abort = 0;
      pin_q = {};
      pin_q.push_back(1'b1);
      pin_q.push_back(1'b1);
   endtask

   function automatic bit exp_nss();
      return m_ssm ? m_ssi : pin_q[0];
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         bit lvl, fnow, nlvl;
         lvl  = exp_nss();
         fnow = m_mst && !lvl;
         m_abort = byte_busy && m_en && !m_mst && lvl;
         if (cfg_we) begin
            m_en   = cfg_wdata[1];
            m_ssm  = cfg_wdata[2];
            m_ssi  = cfg_wdata[3];
            m_ssoe = cfg_wdata[4];
            nlvl   = m_ssm ? m_ssi : pin_q[0];
            m_mst  = cfg_wdata[0] && !m_fault && nlvl;
         end
         if (fnow) begin m_mst = 0; m_en = 0; end
         if (fnow) m_fault = 1;
         else if (fault_clr) m_fault = 0;
         pin_q.push_back(nss_pin_i);
         void'(pin_q.pop_front());
      end
      cycles++;
   end

   task automatic chk(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1/R2 nss_int", nss_int, exp_nss());
         chk("R3/R4 nss_pin_oe", nss_pin_oe, m_mst && m_en && m_ssoe);
         if (nss_pin_oe) chk("R3 nss_pin_o", nss_pin_o, 1'b0);
         chk("R6 slv_sel", slv_sel, m_en && !m_mst && !exp_nss());
         chk("R5/R7 mode_fault", mode_fault, m_fault);
         chk("R5/R8 ctl_master", ctl_master, m_mst);
         chk("R5/R11 ctl_enable", ctl_enable, m_en);
         chk("R9 byte_abort", byte_abort, m_abort);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #2;
   endtask

   task automatic wr(input logic [4:0] v);
      cfg_we = 1'b1; cfg_wdata = v;
      step(1);
      cfg_we = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      step(3);
      // R10: reset state while still in reset
      chk("R10 nss_int", nss_int, 1'b1);
      chk("R10 ctl_master", ctl_master, 1'b0);
      chk("R10 mode_fault", mode_fault, 1'b0);
      chk("R10 nss_pin_oe", nss_pin_oe, 1'b0);
      rst_n = 1'b1;
      step(2);

      // R1: software select high, master, output on; pin toggles ignored
      wr(5'b11111);
      for (int i = 0; i < 6; i++) begin
         nss_pin_i = ~nss_pin_i;
         byte_busy = i[0];
         step(1);
         chk("R1 pin ignored", nss_int, 1'b1);
         chk("R3 held low", nss_pin_oe, 1'b1);
      end
      nss_pin_i = 1'b1; byte_busy = 1'b0;
      // R4: output enable cleared
      wr(5'b01111);
      chk("R4 oe off", nss_pin_oe, 1'b0);

      // R2 and R5: pin-driven master, pin pulled low by another master
      wr(5'b10011);
      step(1);
      chk("R11 master set", ctl_master, 1'b1);
      nss_pin_i = 1'b0;
      step(1);
      chk("R2 one edge", nss_int, 1'b1);
      step(1);
      chk("R2 two edges", nss_int, 1'b0);
      step(1);
      chk("R5 master drop", ctl_master, 1'b0);
      chk("R5 fault set", mode_fault, 1'b1);
      chk("R5 released", nss_pin_oe, 1'b0);
      nss_pin_i = 1'b1;
      step(3);
      // R8: master write blocked while fault set
      wr(5'b10011);
      chk("R8 blocked", ctl_master, 1'b0);
      chk("R8 enable written", ctl_enable, 1'b1);
      fault_clr = 1'b1; step(1); fault_clr = 1'b0;
      chk("R7 cleared", mode_fault, 1'b0);
      // R8: blocked when resulting software level is low
      wr(5'b10111);
      chk("R8 low level", ctl_master, 1'b0);
      wr(5'b11111);
      chk("R8 reentry", ctl_master, 1'b1);

      // R6 / R9: slave with pin select
      wr(5'b00010);
      nss_pin_i = 1'b0;
      step(3);
      chk("R6 selected", slv_sel, 1'b1);
      byte_busy = 1'b1;
      step(2);
      nss_pin_i = 1'b1;
      step(3);
      chk("R9 abort", byte_abort, 1'b1);
      byte_busy = 1'b0;
      step(2);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         cfg_we    = ($urandom_range(0, 7) == 0);
         cfg_wdata = 5'($urandom);
         fault_clr = ($urandom_range(0, 15) == 0);
         byte_busy = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 5) == 0) nss_pin_i = ~nss_pin_i;
         step(1);
      end
      cfg_we = 1'b0; fault_clr = 1'b0;
      step(2);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule